// File: doc/BRIEF.md
# Hamming ECC Syndrome Corrector

This block takes two error-correcting codes for one 256-byte data chunk. The first code is generated while the chunk is read back. The second was kept in spare memory when the chunk was written. The block compares them and sorts the mismatch into one of four outcomes:

- the data is clean;
- only the stored code itself took a hit;
- one data bit flipped, and the block knows where;
- the damage is too wide to repair.

For the repairable case it gives the byte offset inside the chunk and the bit inside that byte. Upstream logic then flips that bit in its buffer.

Each code enters as three bytes packed into a 24-bit word, least significant byte first. The code occupies the low 22 bits and falls into two 11-bit halves. In a healthy code the lower half is a parity field and the upper half is its complement. The block registers one result for each input strobe and pulses a result-valid flag one clock later. A 512-byte page is served by presenting each half-page pair in turn.

Top module: `ecc_syndrome_corrector`

## Requirements
- R1: While reset is held and right after it, `res_valid_o` is 0, `status_o` is 0 and both index outputs are 0.
- R2: Each 24-bit code input carries byte 0 in bits [7:0], byte 1 in [15:8] and byte 2 in [23:16]. Only bits [21:0] of the assembled word count, so bits [23:22] never change any output.
- R3: If the 22-bit calculated and stored codes are equal, or either of them is all zero, `status_o` is 0 (clean).
- R4: Otherwise, if their XOR (the syndrome) has exactly one bit set, `status_o` is 1 (fault in the code field only).
- R5: Otherwise, the status may be 2 (single data bit repaired). This needs the syndrome to have exactly 11 bits set and, for every i in 0..10, syndrome bit i to differ from syndrome bit i+11. In that case `fail_byte_o` equals syndrome bits [10:3] and `fail_bit_o` equals syndrome bits [2:0].
- R6: Every other syndrome gives `status_o` = 3 (uncorrectable).
- R7: `res_valid_o` is high for exactly the one cycle after each cycle in which `in_valid_i` is high, and low otherwise. The outputs in that cycle belong to that strobe.
- R8: `fail_byte_o` and `fail_bit_o` are 0 whenever `status_o` is not 2.
- R9: Between strobes, `status_o` and both index outputs keep the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Both codes are valid this cycle |
| calc_code_i | input | 24 | Code computed from the data read back, byte 0 in the low bits |
| stored_code_i | input | 24 | Code read from spare memory, byte 0 in the low bits |
| res_valid_o | output | 1 | One-cycle pulse marking a new result |
| status_o | output | 2 | 0 clean, 1 code-field fault, 2 repaired, 3 uncorrectable |
| fail_byte_o | output | 8 | Byte offset to repair within the 256-byte chunk |
| fail_bit_o | output | 3 | Bit within that byte to repair |

## Verification
The assertions need only two things from the inputs.

- `in_valid_i` is a known level at every clock edge after reset.
- The code inputs are known whenever the strobe is high.

The assertions place no limit on the gap between strobes or on the code values. The stimulus drives inputs only at falling edges and may leave the codes arbitrary while the strobe is low. It also randomizes the two ignored top bits on every strobe. The stimulus builds its repairable patterns by setting exactly one bit of each parity pair in the syndrome. Its other cases are single flips, double flips, zero codes and free random words. Together these reach every branch of the classification.

// File: rtl/ecc_syn_pkg.sv
package ecc_syn_pkg;

  typedef enum logic [1:0] {
    ECC_CLEAN     = 2'd0,
    ECC_CODE_FLIP = 2'd1,
    ECC_FIXED     = 2'd2,
    ECC_FATAL     = 2'd3
  } ecc_status_e;

endpackage

// File: rtl/ecc_code_unpack.sv
module ecc_code_unpack #(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 3,
  parameter int CODE_W    = 22
) (
  input  logic [BYTE_W*NUM_BYTES-1:0] raw_i,
  output logic [CODE_W-1:0]           code_o,
  output logic                        pad_any_o
);
  localparam int RAW_W = BYTE_W * NUM_BYTES;

  logic [BYTE_W-1:0] byte_lane [NUM_BYTES];
  logic [RAW_W-1:0]  word;

  // byte k of the code lands at bit k*BYTE_W: least significant byte first
  for (genvar k = 0; k < NUM_BYTES; k++) begin : g_lane
    assign byte_lane[k]               = raw_i[k*BYTE_W +: BYTE_W];
    assign word[k*BYTE_W +: BYTE_W]   = byte_lane[k];
  end

  assign code_o = word[CODE_W-1:0];

  if (RAW_W > CODE_W) begin : g_pad
    assign pad_any_o = |word[RAW_W-1:CODE_W];
  end else begin : g_nopad
    assign pad_any_o = 1'b0;
  end
endmodule

// File: rtl/ecc_syndrome_form.sv
module ecc_syndrome_form #(
  parameter int HALF_W = 11
) (
  input  logic [2*HALF_W-1:0] calc_i,
  input  logic [2*HALF_W-1:0] stored_i,
  output logic [2*HALF_W-1:0] syn_o,
  output logic [HALF_W-1:0]   loc_o,
  output logic                pair_all_o,
  output logic                calc_zero_o,
  output logic                stored_zero_o
);
  localparam int CODE_W = 2 * HALF_W;

  // fold a code: parity half against its complement half
  function automatic logic [HALF_W-1:0] fold_halves(input logic [CODE_W-1:0] c);
    return c[HALF_W-1:0] ^ c[CODE_W-1:HALF_W];
  endfunction

  logic [HALF_W-1:0] calc_fold;
  logic [HALF_W-1:0] stored_fold;

  assign syn_o         = calc_i ^ stored_i;
  assign loc_o         = calc_i[HALF_W-1:0] ^ stored_i[HALF_W-1:0];
  assign calc_fold     = fold_halves(calc_i);
  assign stored_fold   = fold_halves(stored_i);
  assign pair_all_o    = &(calc_fold ^ stored_fold);
  assign calc_zero_o   = (calc_i == '0);
  assign stored_zero_o = (stored_i == '0);
endmodule

// File: rtl/ecc_popcount.sv
module ecc_popcount #(
  parameter int W     = 22,
  parameter int CNT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     bits_i,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] partial [W+1];

  assign partial[0] = '0;
  for (genvar g = 0; g < W; g++) begin : g_acc
    assign partial[g+1] = partial[g] + CNT_W'(bits_i[g]);
  end

  assign count_o = partial[W];
endmodule

// File: rtl/ecc_syndrome_corrector.sv
module ecc_syndrome_corrector #(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 3,
  parameter int HALF_W    = 11
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid_i,
  input  logic [BYTE_W*NUM_BYTES-1:0]   calc_code_i,
  input  logic [BYTE_W*NUM_BYTES-1:0]   stored_code_i,
  output logic                          res_valid_o,
  output logic [1:0]                    status_o,
  output logic [HALF_W-$clog2(BYTE_W)-1:0] fail_byte_o,
  output logic [$clog2(BYTE_W)-1:0]     fail_bit_o
);
  import ecc_syn_pkg::*;

  localparam int CODE_W     = 2 * HALF_W;
  localparam int CNT_W      = $clog2(CODE_W + 1);
  localparam int BIT_IDX_W  = $clog2(BYTE_W);
  localparam int BYTE_IDX_W = HALF_W - BIT_IDX_W;

  logic [CODE_W-1:0] calc_code, stored_code;
  logic              calc_pad, stored_pad;
  logic [CODE_W-1:0] syn;
  logic [HALF_W-1:0] loc;
  logic              pair_all, calc_zero, stored_zero;
  logic [CNT_W-1:0]  syn_weight;

  ecc_code_unpack #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES), .CODE_W(CODE_W)) u_unpack_calc (
    .raw_i(calc_code_i), .code_o(calc_code), .pad_any_o(calc_pad)
  );

  ecc_code_unpack #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES), .CODE_W(CODE_W)) u_unpack_stored (
    .raw_i(stored_code_i), .code_o(stored_code), .pad_any_o(stored_pad)
  );

  ecc_syndrome_form #(.HALF_W(HALF_W)) u_form (
    .calc_i(calc_code), .stored_i(stored_code), .syn_o(syn), .loc_o(loc),
    .pair_all_o(pair_all), .calc_zero_o(calc_zero), .stored_zero_o(stored_zero)
  );

  ecc_popcount #(.W(CODE_W), .CNT_W(CNT_W)) u_pop (
    .bits_i(syn), .count_o(syn_weight)
  );

  // classification in priority order
  ecc_status_e status_d;
  always_comb begin
    if (calc_zero || stored_zero || (syn_weight == '0))
      status_d = ECC_CLEAN;
    else if (syn_weight == CNT_W'(1))
      status_d = ECC_CODE_FLIP;
    else if ((syn_weight == CNT_W'(HALF_W)) && pair_all)
      status_d = ECC_FIXED;
    else
      status_d = ECC_FATAL;
  end

  logic                  fix_now;
  logic [BYTE_IDX_W-1:0] byte_d;
  logic [BIT_IDX_W-1:0]  bit_d;
  assign fix_now = (status_d == ECC_FIXED);
  assign byte_d  = fix_now ? loc[HALF_W-1:BIT_IDX_W] : '0;
  assign bit_d   = fix_now ? loc[BIT_IDX_W-1:0]      : '0;

  ecc_status_e           status_q;
  logic                  valid_q;
  logic [BYTE_IDX_W-1:0] byte_q;
  logic [BIT_IDX_W-1:0]  bit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      status_q <= ECC_CLEAN;
      byte_q   <= '0;
      bit_q    <= '0;
    end else begin
      valid_q <= in_valid_i;
      if (in_valid_i) begin
        status_q <= status_d;
        byte_q   <= byte_d;
        bit_q    <= bit_d;
      end
    end
  end

  assign res_valid_o = valid_q;
  assign status_o    = status_q;
  assign fail_byte_o = byte_q;
  assign fail_bit_o  = bit_q;

  AST_RESULT_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid_i |=> res_valid_o); // R7
  AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |-> $past(in_valid_i)); // R7
  AST_IDX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o != ECC_FIXED) |-> (fail_byte_o == '0 && fail_bit_o == '0)); // R8
  AST_ZERO_CODE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && (calc_zero || stored_zero)) |=> status_o == ECC_CLEAN); // R3
  AST_PAD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && (calc_pad || stored_pad) && calc_zero) |=> status_o == ECC_CLEAN); // R2
  AST_SINGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && !calc_zero && !stored_zero && $countones(syn) == 1)
      |=> status_o == ECC_CODE_FLIP); // R4
  AST_PAIRS_REPAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && !calc_zero && !stored_zero && pair_all)
      |=> (status_o == ECC_FIXED && {fail_byte_o, fail_bit_o} == $past(loc))); // R5
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid_i |=> ($stable(status_o) && $stable(fail_byte_o) && $stable(fail_bit_o))); // R9
endmodule

// File: tb/ecc_syndrome_corrector_tb_top.sv
module ecc_syndrome_corrector_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [23:0] calc_code_i = '0;
  logic [23:0] stored_code_i = '0;
  logic        res_valid_o;
  logic [1:0]  status_o;
  logic [7:0]  fail_byte_o;
  logic [2:0]  fail_bit_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_syndrome_corrector dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i),
    .calc_code_i(calc_code_i), .stored_code_i(stored_code_i),
    .res_valid_o(res_valid_o), .status_o(status_o),
    .fail_byte_o(fail_byte_o), .fail_bit_o(fail_bit_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // reference classification, written bit by bit
  function automatic int ref_status(input logic [23:0] c, input logic [23:0] s);
    logic [21:0] cc, ss, d;
    int w;
    bit pairs_ok;
    cc = c[21:0];
    ss = s[21:0];
    d = cc ^ ss;
    w = 0;
    for (int i = 0; i < 22; i++) if (d[i]) w++;
    if (cc == 0 || ss == 0 || w == 0) return 0;
    if (w == 1) return 1;
    pairs_ok = 1;
    for (int i = 0; i < 11; i++) if (d[i] == d[i+11]) pairs_ok = 0;
    if (w == 11 && pairs_ok) return 2;
    return 3;
  endfunction

  function automatic string req_of(input int st);
    case (st)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      default: return "R6";
    endcase
  endfunction

  // one strobe, then one idle cycle with arbitrary codes
  task automatic apply(input logic [23:0] c, input logic [23:0] s, input string force_req);
    int st, eb, ei;
    string rq;
    logic [23:0] d;
    st = ref_status(c, s);
    d = c ^ s;
    eb = (st == 2) ? int'(d[10:3]) : 0;
    ei = (st == 2) ? int'(d[2:0])  : 0;
    rq = (force_req != "") ? force_req : req_of(st);
    @(negedge clk);
    in_valid_i = 1'b1;
    calc_code_i = c;
    stored_code_i = s;
    @(negedge clk);
    check("R7", "result valid", int'(res_valid_o), 1);
    check(rq, "status", int'(status_o), st);
    check((st == 2) ? "R5" : "R8", "fail byte", int'(fail_byte_o), eb);
    check((st == 2) ? "R5" : "R8", "fail bit", int'(fail_bit_o), ei);
    in_valid_i = 1'b0;
    calc_code_i = $urandom();
    stored_code_i = $urandom();
    @(negedge clk);
    check("R7", "idle valid", int'(res_valid_o), 0);
    check("R9", "held status", int'(status_o), st);
    check("R9", "held byte", int'(fail_byte_o), eb);
  endtask

  function automatic logic [23:0] repair_pair(input logic [21:0] base, input logic [10:0] m,
                                               input logic [1:0] pad);
    logic [21:0] pat;
    pat = {~m, m};
    return {pad, base ^ pat};
  endfunction

  initial begin
    void'($urandom(32'h5EED_C0DE));
    #(CLK_PERIOD * 3);
    @(negedge clk);
    check("R1", "reset valid", int'(res_valid_o), 0);
    check("R1", "reset status", int'(status_o), 0);
    check("R1", "reset byte", int'(fail_byte_o), 0);
    check("R1", "reset bit", int'(fail_bit_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "post-reset valid", int'(res_valid_o), 0);

    // directed corners
    apply(24'h000000, 24'h000000, "R3");
    apply(24'h000000, 24'h2A5A5A, "R3");
    apply(24'h15F0F0, 24'h000000, "R3");
    apply(24'h1ACE55, 24'h1ACE55, "R3");
    apply(24'hC00000, 24'h123456, "R2");             // pad-only code counts as zero
    apply(24'h053412, 24'h053412 ^ 24'h020000, "R2"); // byte 2 low bits reach code bit 17
    apply(24'h053412, 24'h053412 ^ 24'h400000, "R2"); // flip only in pad: clean
    apply(24'h0000FF, 24'h0000FE, "R4");
    apply(24'h0ABCDE, repair_pair(22'h0ABCDE, 11'h7FF, 2'b00), "R5");
    apply(24'h0ABCDE, repair_pair(22'h0ABCDE, 11'h000, 2'b00), "R5");
    apply(24'h0ABCDE, repair_pair(22'h0ABCDE, 11'h2C5, 2'b11), "R2");
    apply(24'h0ABCDE, 24'h0ABCDE ^ 24'h000003, "R6");
    apply(24'h0ABCDE, 24'h0ABCDE ^ 24'h000801, "R6"); // one pair both set

    // constrained random
    for (int n = 0; n < 400; n++) begin
      logic [21:0] base;
      logic [1:0] pc, ps;
      logic [23:0] c, s;
      int kind;
      base = 22'($urandom());
      pc = 2'($urandom());
      ps = 2'($urandom());
      kind = int'($urandom_range(0, 5));
      c = {pc, base};
      case (kind)
        0: s = $urandom();
        1: s = {ps, base ^ (22'd1 << $urandom_range(0, 21))};
        2: s = {ps, base ^ (22'd1 << $urandom_range(0, 21)) ^ (22'd1 << $urandom_range(0, 21))};
        3: s = repair_pair(base, 11'($urandom()), ps);
        4: s = {ps, 22'd0};
        default: begin
          s = repair_pair(base, 11'($urandom()), ps);
          s[$urandom_range(0, 21)] ^= 1'b1;
        end
      endcase
      apply(c, s, "");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule